// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the processor-side register file of a two-channel serial controller that also carries a countdown timer. A byte-wide bus with a 4-bit offset reaches sixteen locations. Several offsets mean one thing when read and another when written. The block keeps the channel A byte paths and their status flags. It hands each transmit byte to an external serializer through a valid/acknowledge pair, and it takes received bytes from a byte-valid input. Baud generation, line shifting, the second channel's data path and the general-purpose pins sit outside it.

The timer runs only on cycles where a clock-enable input is high. This lets a slower peripheral clock be modelled without a second clock. When the count reaches zero it raises a flag in an interrupt status register. An interrupt output is the OR of every status bit that is also enabled in a write-only mask. Each bus access takes exactly one clock edge while `bus_sel` is high. With the default parameters, read data is combinational on the current offset.

Top module: `sio_dual_regs`

## Requirements
- R1: Reads at any offset other than 0x3, 0x7, 0xB, 0xC and 0xD return zero, and writes at offsets 0x0, 0x1, 0x2, 0x4, 0x6, 0x8, 0x9, 0xA and 0xB change no register, output or read value.
- R2: A read at offset 0x3 returns the channel status byte: bit 3 is transmitter empty, bit 2 is transmitter ready, bit 1 is receive overrun/full, bit 0 is receive ready, and bits 7..4 are zero. After reset it reads 0x0C.
- R3: A write at offset 0x3 selects the channel clock setting and never alters the status byte or any other readable value.
- R4: A pulse on `rx_valid` stores `rx_data` and sets receive ready. If receive ready was already set and not being cleared by a read in that same cycle, receive full is also set.
- R5: A read at offset 0x7 returns the last stored receive byte and clears both receive ready and receive full. If a byte arrives in the same cycle, the old byte is returned and the new one leaves ready set with full clear.
- R6: A write at offset 0x7 while the transmitter is idle raises `tx_valid` with the byte on `tx_data` from the next cycle on, and clears status bits 3 and 2. A write at 0x7 while `tx_valid` is high is dropped.
- R7: `tx_valid` stays high with a stable byte until `tx_ack` is seen. The cycle after that, `tx_valid` falls and status bits 3 and 2 are set again.
- R8: Writes at 0xC and 0xD set the high and low bytes of the timer preload. A write at 0xE loads the count from the preload and starts counting. Reads at 0xC and 0xD return the high and low bytes of the live count, which is zero after reset.
- R9: While counting, the count decreases by one on each cycle with `tick_en` high and wraps from 0x0000 to 0xFFFF. Without a tick, or while stopped, it holds.
- R10: A tick that takes the count to zero sets interrupt status bit 3. A write at offset 0xF stops counting and clears that bit. Ticks while stopped leave both the count and the bit unchanged.
- R11: A read at offset 0xB returns the interrupt status byte: bit 0 is transmitter ready, bit 1 is receive ready, bit 3 is the timer flag, and all other bits are zero.
- R12: `irq` is high exactly when some interrupt status bit is set and the same bit of the mask is set. The mask is written at offset 0x5 and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per edge |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (zero when no read is in progress) |
| tick_en | input | 1 | Timer clock-enable tick |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ack | input | 1 | Serializer has taken the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| irq | output | 1 | Masked interrupt request |

## Verification
The properties assume that `tx_ack` is only meaningful while `tx_valid` is high, that `rx_valid` and `tick_en` are single-cycle pulses sampled on the edge, and that a bus access is presented for exactly one edge. The bench keeps within these limits. It drives every access, receive strobe, tick and acknowledge from tasks that assert the signal at a falling edge and drop it just after the next rising edge. It raises `tx_ack` only when its own model says a byte is pending, except for one deliberate stray acknowledge that must be ignored. The simultaneous read-and-arrival case is driven as a single combined cycle, so the ordering rule of R5 is exercised without breaking the one-access-per-edge assumption.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;

   // Offsets whose meaning the surrounding software depends on
   localparam logic [3:0] OFF_CHAN_STAT = 4'h3;   // rd: status, wr: clock setting
   localparam logic [3:0] OFF_IRQ_MASK  = 4'h5;   // wr only
   localparam logic [3:0] OFF_CHAN_DATA = 4'h7;   // rd: rx byte, wr: tx byte
   localparam logic [3:0] OFF_IRQ_STAT  = 4'hB;   // rd only
   localparam logic [3:0] OFF_TMR_HI    = 4'hC;   // rd: count hi, wr: preload hi
   localparam logic [3:0] OFF_TMR_LO    = 4'hD;   // rd: count lo, wr: preload lo
   localparam logic [3:0] OFF_TMR_GO    = 4'hE;   // wr: load and start
   localparam logic [3:0] OFF_TMR_HALT  = 4'hF;   // wr: stop and clear flag

   // Channel status bit positions
   localparam int ST_RX_READY = 0;
   localparam int ST_RX_FULL  = 1;
   localparam int ST_TX_READY = 2;
   localparam int ST_TX_EMPTY = 3;

   // Interrupt status bit positions
   localparam int IS_TX_READY = 0;
   localparam int IS_RX_READY = 1;
   localparam int IS_TIMER    = 3;

   // Decoded single-cycle access strobes
   typedef struct packed {
      logic rd_any;
      logic rd_data;
      logic wr_data;
      logic wr_mask;
      logic wr_pre_hi;
      logic wr_pre_lo;
      logic wr_go;
      logic wr_halt;
   } sio_strobe_t;

endpackage

// File: rtl/sio_decode.sv
module sio_decode
   import sio_regs_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output sio_strobe_t       stb
);

   logic rd_en;
   logic wr_en;

   assign rd_en = sel & ~wr;
   assign wr_en = sel & wr;

   always_comb begin
      stb           = '0;
      stb.rd_any    = rd_en;
      stb.rd_data   = rd_en & (addr == OFF_CHAN_DATA);
      stb.wr_data   = wr_en & (addr == OFF_CHAN_DATA);
      stb.wr_mask   = wr_en & (addr == OFF_IRQ_MASK);
      stb.wr_pre_hi = wr_en & (addr == OFF_TMR_HI);
      stb.wr_pre_lo = wr_en & (addr == OFF_TMR_LO);
      stb.wr_go     = wr_en & (addr == OFF_TMR_GO);
      stb.wr_halt   = wr_en & (addr == OFF_TMR_HALT);
   end

endmodule

// File: rtl/sio_chan.sv
module sio_chan #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_tx,
   input  logic              rd_rx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              tx_ack,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_ready,
   output logic              rx_full
);

   logic              tx_busy;
   logic [DATA_W-1:0] tx_hold;

   // Receive side: arrival takes precedence over a same-cycle read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte  <= '0;
         rx_ready <= 1'b0;
         rx_full  <= 1'b0;
      end else if (rx_valid) begin
         rx_byte  <= rx_data;
         rx_ready <= 1'b1;
         rx_full  <= rx_ready & ~rd_rx;
      end else if (rd_rx) begin
         rx_ready <= 1'b0;
         rx_full  <= 1'b0;
      end
   end

   // Transmit side: one byte in flight, new writes dropped while busy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_busy <= 1'b0;
         tx_hold <= '0;
      end else if (!tx_busy) begin
         if (wr_tx) begin
            tx_busy <= 1'b1;
            tx_hold <= wdata;
         end
      end else if (tx_ack) begin
         tx_busy <= 1'b0;
      end
   end

   assign tx_valid = tx_busy;
   assign tx_data  = tx_hold;

endmodule

// File: rtl/sio_timer.sv
module sio_timer #(
   parameter int DATA_W  = 8,
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               wr_pre_hi,
   input  logic               wr_pre_lo,
   input  logic               go,
   input  logic               halt,
   input  logic [DATA_W-1:0]  wdata,
   output logic [TIMER_W-1:0] count,
   output logic               running,
   output logic               flag
);

   localparam int HI_W = TIMER_W - DATA_W;
   localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

   logic [TIMER_W-1:0] preload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preload <= '0;
      end else begin
         if (wr_pre_hi) preload[TIMER_W-1:DATA_W] <= wdata[HI_W-1:0];
         if (wr_pre_lo) preload[DATA_W-1:0]       <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         running <= 1'b0;
         flag    <= 1'b0;
      end else if (go) begin
         count   <= preload;
         running <= 1'b1;
      end else if (halt) begin
         running <= 1'b0;
         flag    <= 1'b0;
      end else if (running && tick) begin
         count <= count - ONE;
         if (count == ONE) flag <= 1'b1;
      end
   end

endmodule

// File: rtl/sio_dual_regs.sv
module sio_dual_regs
   import sio_regs_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int TIMER_W = 16,
   parameter bit RD_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_en,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ack,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              irq
);

   localparam int HI_W = TIMER_W - DATA_W;

   // Elaboration-time parameter checks
   generate
      if (ADDR_W != 4) begin : g_bad_addr
         $error("sio_dual_regs: ADDR_W must be 4");
      end
      if (DATA_W < 4) begin : g_bad_data
         $error("sio_dual_regs: DATA_W must be at least 4");
      end
      if (TIMER_W <= DATA_W || TIMER_W > 2 * DATA_W) begin : g_bad_tmr
         $error("sio_dual_regs: TIMER_W must span two data bytes");
      end
   endgenerate

   sio_strobe_t        stb;
   logic [DATA_W-1:0]  rx_byte_w;
   logic               rx_ready_w;
   logic               rx_full_w;
   logic [TIMER_W-1:0] tmr_cnt_w;
   logic               tmr_run_w;
   logic               tmr_flag_w;
   logic [DATA_W-1:0]  irq_mask;
   logic [DATA_W-1:0]  chan_stat;
   logic [DATA_W-1:0]  irq_stat;
   logic [DATA_W-1:0]  rd_mux;

   sio_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel  (bus_sel),
      .wr   (bus_wr),
      .addr (bus_addr),
      .stb  (stb)
   );

   sio_chan #(.DATA_W(DATA_W)) u_chan_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_tx    (stb.wr_data),
      .rd_rx    (stb.rd_data),
      .wdata    (bus_wdata),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .tx_ack   (tx_ack),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .rx_byte  (rx_byte_w),
      .rx_ready (rx_ready_w),
      .rx_full  (rx_full_w)
   );

   sio_timer #(.DATA_W(DATA_W), .TIMER_W(TIMER_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_en),
      .wr_pre_hi (stb.wr_pre_hi),
      .wr_pre_lo (stb.wr_pre_lo),
      .go        (stb.wr_go),
      .halt      (stb.wr_halt),
      .wdata     (bus_wdata),
      .count     (tmr_cnt_w),
      .running   (tmr_run_w),
      .flag      (tmr_flag_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           irq_mask <= '0;
      else if (stb.wr_mask) irq_mask <= bus_wdata;
   end

   always_comb begin
      chan_stat              = '0;
      chan_stat[ST_RX_READY] = rx_ready_w;
      chan_stat[ST_RX_FULL]  = rx_full_w;
      chan_stat[ST_TX_READY] = ~tx_valid;
      chan_stat[ST_TX_EMPTY] = ~tx_valid;

      irq_stat               = '0;
      irq_stat[IS_TX_READY]  = ~tx_valid;
      irq_stat[IS_RX_READY]  = rx_ready_w;
      irq_stat[IS_TIMER]     = tmr_flag_w;
   end

   assign irq = |(irq_stat & irq_mask);

   always_comb begin
      rd_mux = '0;
      if (stb.rd_any) begin
         unique case (bus_addr)
            OFF_CHAN_STAT: rd_mux = chan_stat;
            OFF_CHAN_DATA: rd_mux = rx_byte_w;
            OFF_IRQ_STAT:  rd_mux = irq_stat;
            OFF_TMR_HI:    rd_mux = DATA_W'(tmr_cnt_w[TIMER_W-1 -: HI_W]);
            OFF_TMR_LO:    rd_mux = tmr_cnt_w[DATA_W-1:0];
            default:       rd_mux = '0;
         endcase
      end
   end

   // Read data path variant
   generate
      if (RD_PIPE) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate

endmodule

// File: rtl/sio_dual_regs_chk.sv
module sio_dual_regs_chk #(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int TIMER_W = 16,
   parameter bit RD_PIPE = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               tick_en,
   input logic               rx_valid,
   input logic               tx_ack,
   input logic               tx_valid,
   input logic [DATA_W-1:0]  tx_data,
   input logic               rx_ready,
   input logic               rx_full,
   input logic [TIMER_W-1:0] tmr_cnt,
   input logic               tmr_run,
   input logic               tmr_flag
);

   logic rd_rx_acc;
   logic wr_tx_acc;
   logic tmr_ctl;
   logic rd_unused;

   assign rd_rx_acc = bus_sel && !bus_wr && (bus_addr == 4'h7);
   assign wr_tx_acc = bus_sel && bus_wr && (bus_addr == 4'h7);
   assign tmr_ctl   = bus_sel && bus_wr && (bus_addr == 4'hE || bus_addr == 4'hF);
   assign rd_unused = bus_sel && !bus_wr && !(bus_addr == 4'h3 || bus_addr == 4'h7 ||
                      bus_addr == 4'hB || bus_addr == 4'hC || bus_addr == 4'hD);

   // R1
   unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!RD_PIPE && rd_unused) |-> (bus_rdata == '0));

   // R4
   rx_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> rx_ready);

   // R4
   rx_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready && !rd_rx_acc) |=> rx_full);

   // R5
   rx_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx_acc && !rx_valid) |=> (!rx_ready && !rx_full));

   // R6
   tx_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tx_acc && !tx_valid) |=> (tx_valid && tx_data == $past(bus_wdata)));

   // R7
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ack) |=> (tx_valid && $stable(tx_data)));

   // R7
   tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ack) |=> !tx_valid);

   // R9
   tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_run && tick_en && !tmr_ctl) |=> (tmr_cnt == $past(tmr_cnt) - TIMER_W'(1)));

   // R9
   tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!tick_en || !tmr_run) && !tmr_ctl) |=> $stable(tmr_cnt));

   // R10
   tmr_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_flag) |-> (tmr_cnt == '0));

   // R10
   tmr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == 4'hF) |=> (!tmr_run && !tmr_flag));

endmodule

bind sio_dual_regs sio_dual_regs_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .TIMER_W (TIMER_W),
   .RD_PIPE (RD_PIPE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .tick_en   (tick_en),
   .rx_valid  (rx_valid),
   .tx_ack    (tx_ack),
   .tx_valid  (tx_valid),
   .tx_data   (tx_data),
   .rx_ready  (rx_ready_w),
   .rx_full   (rx_full_w),
   .tmr_cnt   (tmr_cnt_w),
   .tmr_run   (tmr_run_w),
   .tmr_flag  (tmr_flag_w)
);

// File: tb/sio_dual_regs_tb.sv
module sio_dual_regs_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       tick_en = 1'b0;
   logic [7:0] tx_data;
   logic       tx_valid;
   logic       tx_ack = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_valid = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Bench-side model of the architected state
   logic [7:0]  m_rx = '0;
   logic        m_rdy = 1'b0;
   logic        m_full = 1'b0;
   logic        m_busy = 1'b0;
   logic [7:0]  m_txd = '0;
   logic [15:0] m_cnt = '0;
   logic [15:0] m_pre = '0;
   logic        m_run = 1'b0;
   logic        m_flag = 1'b0;
   logic [7:0]  m_mask = '0;

   always #2 clk = ~clk;

   sio_dual_regs u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick_en   (tick_en),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_ack    (tx_ack),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .irq       (irq)
   );

   function automatic logic [7:0] m_isr();
      return {4'b0, m_flag, 1'b0, m_rdy, ~m_busy};
   endfunction

   function automatic logic [7:0] m_read(input logic [3:0] a);
      case (a)
         4'h3:    return {4'b0, ~m_busy, ~m_busy, m_full, m_rdy};
         4'h7:    return m_rx;
         4'hB:    return m_isr();
         4'hC:    return m_cnt[15:8];
         4'hD:    return m_cnt[7:0];
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
      case (a)
         4'h5: m_mask = d;
         4'h7: if (!m_busy) begin m_busy = 1'b1; m_txd = d; end
         4'hC: m_pre[15:8] = d;
         4'hD: m_pre[7:0] = d;
         4'hE: begin m_cnt = m_pre; m_run = 1'b1; end
         4'hF: begin m_run = 1'b0; m_flag = 1'b0; end
         default: ;
      endcase
   endtask

   task automatic rd(input logic [3:0] a, input string req);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 check(req, {8'h0, bus_rdata}, {8'h0, m_read(a)});
      @(posedge clk);
      #1 bus_sel = 1'b0;
      if (a == 4'h7) begin m_rdy = 1'b0; m_full = 1'b0; end
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(posedge clk);
      #1 rx_valid = 1'b0;
      m_full = m_rdy; m_rdy = 1'b1; m_rx = b;
   endtask

   task automatic rd_push(input logic [7:0] b);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h7;
      rx_valid = 1'b1; rx_data = b;
      #1 check("R5 same-cycle read", {8'h0, bus_rdata}, {8'h0, m_rx});
      @(posedge clk);
      #1 bus_sel = 1'b0; rx_valid = 1'b0;
      m_rx = b; m_rdy = 1'b1; m_full = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      tick_en = 1'b1;
      @(posedge clk);
      #1 tick_en = 1'b0;
      if (m_run) begin
         m_cnt = m_cnt - 16'd1;
         if (m_cnt == 16'd0) m_flag = 1'b1;
      end
   endtask

   task automatic ack();
      @(negedge clk);
      tx_ack = 1'b1;
      @(posedge clk);
      #1 tx_ack = 1'b0;
      m_busy = 1'b0;
   endtask

   task automatic chk_ports(input string req);
      @(negedge clk);
      check({req, " tx_valid"}, {15'h0, tx_valid}, {15'h0, m_busy});
      check({req, " tx_data"}, {8'h0, tx_data}, {8'h0, m_txd});
      check({req, " irq"}, {15'h0, irq}, {15'h0, |(m_isr() & m_mask)});
   endtask

   task automatic rd_all(input string req);
      for (int a = 0; a < 16; a++) rd(4'(a), req);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // Reset state: full sweep of the read map (R1 R2 R11 R8 R12)
      rd_all("R1 R2 R11 reset read map");
      chk_ports("R12 reset");

      // R1: writes at unused offsets leave every readable value alone
      for (int a = 0; a < 16; a++) begin
         if (a == 0 || a == 1 || a == 2 || a == 4 || a == 6 || a == 8 ||
             a == 9 || a == 10 || a == 11) begin
            wr(4'(a), 8'hFF);
            wr(4'(a), 8'h5A);
         end
      end
      rd_all("R1 after unused writes");
      chk_ports("R1 ports");

      // R3: clock setting writes at the status offset
      for (int v = 0; v < 256; v += 17) begin
         wr(4'h3, 8'(v));
         rd(4'h3, "R3 status after clock write");
      end

      // R4 R5 R2 R11: every receive byte value
      for (int b = 0; b < 256; b++) begin
         push(8'(b));
         rd(4'h3, "R4 R2 ready after arrival");
         rd(4'hB, "R11 rx ready isr");
         rd(4'h7, "R5 rx byte");
         rd(4'h3, "R5 cleared after read");
      end

      // R4: overrun sets full, R5 read clears both
      push(8'h12);
      push(8'h34);
      rd(4'h3, "R4 full after second arrival");
      rd(4'h7, "R5 newest byte kept");
      rd(4'h3, "R5 full cleared");

      // R5: read and arrival in the same cycle
      push(8'h77);
      rd_push(8'h88);
      rd(4'h3, "R5 ready stays, full clear");
      rd(4'h7, "R5 new byte");

      // R6 R7: transmit handshake
      wr(4'h7, 8'hA5);
      chk_ports("R6 launch");
      rd(4'h3, "R6 tx bits cleared");
      rd(4'hB, "R6 R11 tx ready low");
      wr(4'h7, 8'h11);
      chk_ports("R6 write while busy dropped");
      repeat (3) @(posedge clk);
      chk_ports("R7 held until ack");
      ack();
      chk_ports("R7 after ack");
      rd(4'h3, "R7 tx bits restored");
      // stray ack with nothing pending has no effect
      @(negedge clk); tx_ack = 1'b1; @(posedge clk); #1 tx_ack = 1'b0;
      chk_ports("R7 stray ack");
      for (int v = 0; v < 8; v++) begin
         wr(4'h7, 8'(v * 37));
         chk_ports("R6 sweep");
         ack();
      end

      // R12: mask sweep over each status source
      for (int m = 0; m < 256; m += 5) begin
         wr(4'h5, 8'(m));
         chk_ports("R12 mask sweep idle");
         rd(4'h5, "R1 mask write-only");
      end
      wr(4'h5, 8'h02);
      chk_ports("R12 rx masked only");
      push(8'h42);
      chk_ports("R12 rx raises irq");
      rd(4'h7, "R5 read for irq");
      chk_ports("R12 irq drops after read");

      // R8 R9 R10: timer with small preloads
      wr(4'h5, 8'h08);
      for (int n = 1; n <= 24; n++) begin
         wr(4'hC, 8'h00);
         wr(4'hD, 8'(n));
         wr(4'hE, 8'h00);
         rd(4'hD, "R8 count loaded");
         for (int k = 1; k < n; k++) begin
            tick();
            @(negedge clk);
         end
         rd(4'hD, "R9 count before zero");
         rd(4'hB, "R10 flag not yet set");
         // idle cycles without tick hold the count
         repeat (3) @(posedge clk);
         rd(4'hD, "R9 hold without tick");
         tick();
         rd(4'hB, "R10 flag at zero");
         chk_ports("R10 R12 timer irq");
         tick();
         rd(4'hC, "R9 wrap high");
         rd(4'hD, "R9 wrap low");
         rd(4'hB, "R10 flag sticky");
         wr(4'hF, 8'h00);
         rd(4'hB, "R10 halt clears flag");
         tick();
         rd(4'hD, "R10 stopped count holds");
         chk_ports("R10 irq cleared");
      end

      // R8: high byte preload and count readback
      wr(4'hC, 8'h12);
      wr(4'hD, 8'h34);
      wr(4'hE, 8'h00);
      rd(4'hC, "R8 count high");
      rd(4'hD, "R8 count low");
      tick();
      rd(4'hD, "R9 low decrement");

      // R9: preload zero wraps at once without raising the flag
      wr(4'hF, 8'h00);
      wr(4'hC, 8'h00);
      wr(4'hD, 8'h00);
      wr(4'hE, 8'h00);
      tick();
      rd(4'hC, "R9 zero wrap high");
      rd(4'hB, "R10 no flag on wrap from zero");

      // R9: borrow across the byte boundary
      wr(4'hC, 8'h01);
      wr(4'hD, 8'h01);
      wr(4'hE, 8'h00);
      tick();
      tick();
      rd(4'hC, "R9 borrow high");
      rd(4'hD, "R9 borrow low");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule